// File: doc/BRIEF.md
# Serial Lock Monitor with Reference Fallback

This block decides, one received bit at a time, whether clock recovery on a serial link can be trusted. It runs on the recovered bit clock and takes the retimed serial bit. It tracks two measures. The first is the length of the current run of identical bits. The second is how many bit-to-bit transitions fell inside the most recent 256-bit span. If either measure breaks its limit, the monitor reports that lock is lost. It also moves its clock-source select to the local reference, so downstream logic keeps a clock of the right frequency.

After reset, or after lock is lost, the monitor starts on the reference. It goes back to data-locked clocking only after a full window of clean traffic. A force input keeps it on the reference for as long as it is high. A slip in the data, where one bit is added or lost, leaves both measures inside their limits, so it does not break lock.

Top module: `lock_mon`

## Requirements
- R1: While reset is low and just after reset, `lock_n` is 1 (not locked) and `sel_ref` is 1 (reference clocking). After reset, the bit before the first sampled bit is taken as 0.
- R2: A bit that makes 65 consecutive identical bits drives `lock_n` to 1 on the clock edge that samples it. A run of exactly 64 identical bits causes no loss.
- R3: The monitor counts transitions over the last 256 sampled bits. If that count falls below 31, lock is lost. A pattern with one transition every 8 bits (32 per window) keeps lock. A pattern with one transition every 9 bits loses lock and cannot regain it.
- R4: `sel_ref` is 0 (recovered-data clocking) exactly while `lock_n` is 0. On loss of lock, both go to 1 on the same edge.
- R5: From the not-locked state, `lock_n` falls to 0 at the edge that samples the 256th consecutive bit that has no run violation and no force, provided the window count is at least 31 at that point. It does not fall earlier.
- R6: In dense data, one inserted bit or one dropped bit leaves `lock_n` at 0.
- R7: Any bit sampled with `force_ref` = 1 drives `lock_n` and `sel_ref` to 1 at that edge. Bits sampled under force do not count toward the 256 clean bits of R5.
- R8: `lock_n` rises only at an edge that samples a run violation, a window count below 31, or force. With none of these, a locked monitor stays locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Retimed serial data bit |
| force_ref | input | 1 | 1 holds the monitor on reference clocking |
| lock_n | output | 1 | Registered lock flag, 0 = locked to data |
| sel_ref | output | 1 | Registered clock-source select, 1 = reference, 0 = recovered data |

## Verification
Both outputs are registered. Each one reflects the bit and force value sampled at a rising edge right after that edge. So the run-limit loss appears after the edge of the 65th identical bit, and reacquisition appears after the edge of the 256th clean bit. The bench drives each bit and force value just after a falling edge and holds it through exactly one rising edge. It compares the outputs at the next falling edge, after the last bit of a segment has been sampled. The run-limit and reacquisition boundaries are checked one bit before and exactly at the edge where the change is due. The density cases are checked once the 256-bit window has filled entirely with the new pattern.

// File: rtl/lock_mon_pkg.sv
package lock_mon_pkg;

    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } lm_state_e;

endpackage

// File: rtl/lock_mon_run.sv
// Run-length tracker: flags each bit-to-bit transition and a run that
// grows past the configured limit.
module lock_mon_run #(
    parameter int RUN_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    output logic edge_o,
    output logic run_viol_o
);

    localparam int RUN_MAX = RUN_LIMIT + 1;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    typedef struct packed {
        logic             prev;
        logic [RUN_W-1:0] run;
    } run_st_t;

    run_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        edge_o   = bit_i ^ s_q.prev;
        s_d.prev = bit_i;
        if (edge_o) begin
            s_d.run = RUN_W'(1);
        end else if (s_q.run != RUN_W'(RUN_MAX)) begin
            s_d.run = s_q.run + 1'b1;
        end
        run_viol_o = (s_d.run > RUN_W'(RUN_LIMIT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/lock_mon_density.sv
// Sliding-window transition counter: keeps the last WIN_LEN transition
// flags and their population count.
module lock_mon_density #(
    parameter int WIN_LEN   = 256,
    parameter int MIN_TRANS = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic dens_low_o
);

    localparam int CNT_W = $clog2(WIN_LEN + 1);

    typedef struct packed {
        logic [WIN_LEN-1:0] hist;
        logic [CNT_W-1:0]   cnt;
    } win_st_t;

    win_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.hist = {s_q.hist[WIN_LEN-2:0], edge_i};
        s_d.cnt  = s_q.cnt + CNT_W'(edge_i) - CNT_W'(s_q.hist[WIN_LEN-1]);
        dens_low_o = (s_d.cnt < CNT_W'(MIN_TRANS));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/lock_mon_fsm.sv
// Lock decision: qualifies a full clean window before locking, drops back
// to the reference on any violation or force.
module lock_mon_fsm
    import lock_mon_pkg::*;
#(
    parameter int WIN_LEN = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_viol_i,
    input  logic dens_low_i,
    input  logic force_i,
    output logic qual_ok_o,
    output logic lock_n_o,
    output logic sel_ref_o
);

    localparam int QW = $clog2(WIN_LEN + 1);

    typedef struct packed {
        lm_state_e     st;
        logic [QW-1:0] qual;
        logic          lock_n;
        logic          sel_ref;
    } fsm_st_t;

    fsm_st_t     s_d, s_q;
    logic        drop;
    logic [QW-1:0] qual_n;

    always_comb begin
        s_d  = s_q;
        drop = run_viol_i | force_i;

        if (drop) begin
            qual_n = '0;
        end else if (s_q.qual != QW'(WIN_LEN)) begin
            qual_n = s_q.qual + 1'b1;
        end else begin
            qual_n = s_q.qual;
        end
        qual_ok_o = (qual_n == QW'(WIN_LEN));
        s_d.qual  = qual_n;

        case (s_q.st)
            ST_HUNT: begin
                if (qual_ok_o && !dens_low_i) begin
                    s_d.st = ST_LOCKED;
                end
            end
            ST_LOCKED: begin
                if (drop || dens_low_i) begin
                    s_d.st   = ST_HUNT;
                    s_d.qual = '0;
                end
            end
            default: begin
                s_d.st   = ST_HUNT;
                s_d.qual = '0;
            end
        endcase

        s_d.lock_n  = (s_d.st != ST_LOCKED);
        s_d.sel_ref = (s_d.st != ST_LOCKED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st      <= ST_HUNT;
            s_q.qual    <= '0;
            s_q.lock_n  <= 1'b1;
            s_q.sel_ref <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign lock_n_o  = s_q.lock_n;
    assign sel_ref_o = s_q.sel_ref;

endmodule

// File: rtl/lock_mon.sv
module lock_mon #(
    parameter int RUN_LIMIT = 64,
    parameter int WIN_LEN   = 256,
    parameter int MIN_TRANS = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic force_ref,
    output logic lock_n,
    output logic sel_ref
);

    logic bit_edge;
    logic run_viol;
    logic dens_low;
    logic qual_ok;

    lock_mon_run #(
        .RUN_LIMIT(RUN_LIMIT)
    ) run_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_i     (bit_in),
        .edge_o    (bit_edge),
        .run_viol_o(run_viol)
    );

    lock_mon_density #(
        .WIN_LEN  (WIN_LEN),
        .MIN_TRANS(MIN_TRANS)
    ) dens_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (bit_edge),
        .dens_low_o(dens_low)
    );

    lock_mon_fsm #(
        .WIN_LEN(WIN_LEN)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_viol_i(run_viol),
        .dens_low_i(dens_low),
        .force_i   (force_ref),
        .qual_ok_o (qual_ok),
        .lock_n_o  (lock_n),
        .sel_ref_o (sel_ref)
    );

endmodule

// File: rtl/lock_mon_chk.sv
module lock_mon_chk (
    input logic clk,
    input logic rst_n,
    input logic force_ref,
    input logic lock_n,
    input logic sel_ref,
    input logic run_viol,
    input logic dens_low,
    input logic qual_ok
);

    // R2
    run_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_viol |=> lock_n);

    // R3
    dens_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dens_low |=> lock_n);

    // R4
    sel_on_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_n) |-> sel_ref);

    // R4
    sel_on_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> !sel_ref);

    // R5
    no_early_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> $past(qual_ok));

    // R7
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_ref |=> (lock_n && sel_ref));

    // R8
    loss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_n) |-> $past(run_viol || dens_low || force_ref));

endmodule

bind lock_mon lock_mon_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .force_ref(force_ref),
    .lock_n   (lock_n),
    .sel_ref  (sel_ref),
    .run_viol (run_viol),
    .dens_low (dens_low),
    .qual_ok  (qual_ok)
);

// File: tb/lock_mon_tb_top.sv
module lock_mon_tb_top;

    localparam logic [9:0] KWORD = 10'b0011111010;

    localparam logic [1:0] P_K    = 2'd0;
    localparam logic [1:0] P_ONES = 2'd1;
    localparam logic [1:0] P_R8   = 2'd2;
    localparam logic [1:0] P_R9   = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] len;
        logic        frc;
        logic        exp_lock_n;
        logic        exp_sel;
        logic [3:0]  req;
    } seg_t;

    localparam int NSEG = 19;
    localparam seg_t SEGS [NSEG] = '{
        '{P_K,    16'd255, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 one bit short
        '{P_K,    16'd1,   1'b0, 1'b0, 1'b0, 4'd5},  // R5 lock at 256th
        '{P_K,    16'd304, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 data clocking
        '{P_ONES, 16'd64,  1'b0, 1'b0, 1'b0, 4'd2},  // R2 run of 64
        '{P_K,    16'd20,  1'b0, 1'b0, 1'b0, 4'd2},
        '{P_ONES, 16'd64,  1'b0, 1'b0, 1'b0, 4'd8},  // R8 no cause
        '{P_ONES, 16'd1,   1'b0, 1'b1, 1'b1, 4'd2},  // R2 65th bit
        '{P_ONES, 16'd30,  1'b0, 1'b1, 1'b1, 4'd4},  // R4 on reference
        '{P_K,    16'd255, 1'b0, 1'b1, 1'b1, 4'd5},
        '{P_K,    16'd1,   1'b0, 1'b0, 1'b0, 4'd5},
        '{P_K,    16'd4,   1'b0, 1'b0, 1'b0, 4'd5},
        '{P_R8,   16'd512, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 32 per window
        '{P_R9,   16'd512, 1'b0, 1'b1, 1'b1, 4'd3},  // R3 28/29 per window
        '{P_K,    16'd300, 1'b0, 1'b0, 1'b0, 4'd5},
        '{P_K,    16'd10,  1'b1, 1'b1, 1'b1, 4'd7},  // R7 force
        '{P_K,    16'd290, 1'b1, 1'b1, 1'b1, 4'd7},
        '{P_K,    16'd255, 1'b0, 1'b1, 1'b1, 4'd7},
        '{P_K,    16'd1,   1'b0, 1'b0, 1'b0, 4'd7},
        '{P_K,    16'd4,   1'b0, 1'b0, 1'b0, 4'd7}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic force_ref = 1'b0;
    logic lock_n;
    logic sel_ref;

    int n_chk = 0;
    int n_bad = 0;
    int kpos = 0;
    logic prev_bit = 1'b0;
    logic [1:0] last_kind = P_ONES;

    always #2 clk = ~clk;

    lock_mon dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (bit_in),
        .force_ref(force_ref),
        .lock_n   (lock_n),
        .sel_ref  (sel_ref)
    );

    function automatic string rq(input int n);
        case (n)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input logic act, input logic exp, input string req,
                         input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Caller sits at a falling edge; value is held through one rising edge.
    task automatic send_bit(input logic b, input logic f);
        bit_in    = b;
        force_ref = f;
        prev_bit  = b;
        @(negedge clk);
    endtask

    task automatic send_k(input int n, input logic f);
        for (int i = 0; i < n; i++) begin
            send_bit(KWORD[9 - (kpos % 10)], f);
            kpos++;
        end
    endtask

    task automatic run_seg(input seg_t s);
        logic start;
        if (s.kind == P_K && last_kind != P_K) kpos = 0;
        start = ~prev_bit;
        case (s.kind)
            P_K:    send_k(int'(s.len), s.frc);
            P_ONES: for (int i = 0; i < int'(s.len); i++) send_bit(1'b1, s.frc);
            P_R8:   for (int i = 0; i < int'(s.len); i++)
                        send_bit(start ^ ((i / 8) % 2 == 1), s.frc);
            default: for (int i = 0; i < int'(s.len); i++)
                        send_bit(start ^ ((i / 9) % 2 == 1), s.frc);
        endcase
        last_kind = s.kind;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic seen_high;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(lock_n, 1'b1, "R1", "lock_n in reset");
        check(sel_ref, 1'b1, "R1", "sel_ref in reset");
        rst_n = 1'b1;

        for (int s = 0; s < NSEG; s++) begin
            run_seg(SEGS[s]);
            check(lock_n, SEGS[s].exp_lock_n, rq(int'(SEGS[s].req)),
                  $sformatf("lock_n after segment %0d", s));
            check(sel_ref, SEGS[s].exp_sel, rq(int'(SEGS[s].req)),
                  $sformatf("sel_ref after segment %0d", s));
        end

        // R6: inserted bit, then dropped bit, in dense data
        seen_high = 1'b0;
        for (int i = 0; i < 5; i++) begin
            send_k(1, 1'b0);
            if (lock_n) seen_high = 1'b1;
        end
        send_bit(prev_bit, 1'b0);
        if (lock_n) seen_high = 1'b1;
        for (int i = 0; i < 300; i++) begin
            send_k(1, 1'b0);
            if (lock_n) seen_high = 1'b1;
        end
        kpos++;
        for (int i = 0; i < 200; i++) begin
            send_k(1, 1'b0);
            if (lock_n) seen_high = 1'b1;
        end
        check(seen_high, 1'b0, "R6", "lock_n rose across slips");

        // R1: reset while locked
        rst_n = 1'b0;
        prev_bit = 1'b0;
        @(negedge clk);
        check(lock_n, 1'b1, "R1", "lock_n after mid reset");
        check(sel_ref, 1'b1, "R1", "sel_ref after mid reset");
        rst_n = 1'b1;
        kpos = 0;
        send_k(200, 1'b0);
        check(lock_n, 1'b1, "R5", "lock_n after 200 clean bits");
        send_k(56, 1'b0);
        check(lock_n, 1'b0, "R5", "lock_n after 256 clean bits");
        check(sel_ref, 1'b0, "R4", "sel_ref after relock");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule